// File: doc/BRIEF.md
# Paged Indirect Register Window Decoder

This block is a 32-bit register slave whose physical aperture is smaller than the logical register space it serves. Logical byte offsets below 0xC00 map straight onto the physical space. Every offset from 0xC00 upward goes through a fixed 1 KB window at physical 0xC00..0xFFF. A six-bit page field decides which backing page that window shows, and the field sits inside an ordinary control register at offset 0x808.

Each logical access runs as a short fixed sequence. The block first reads the control register. It then writes the control register back with the page field replaced and every other bit kept. Only after that does it perform the data read or write at the translated physical address. A single-cycle ready marks the end of the access, and read data is valid while ready is high. The window storage implements `PAGE_BANKS` pages, selected by the low bits of the page field.

Top module: `pgw_window_dec`

## Requirements
- R1: After synchronous reset, busy and ready are low and every register, including the control register at 0x808, reads as zero.
- R2: Offsets below 0xC00 access the word at that offset directly. Before the data access, the page field is set to 0.
- R3: An offset at or above 0xC00 uses page = offset[15:10] and physical address = (offset & 0x3FF) | 0xC00. Pages that differ in their low log2(PAGE_BANKS) bits hold separate data.
- R4: The page field is bits 18:13 of the control register at 0x808. A page update keeps all other bits of that register, including the enable bits 0 and 1.
- R5: The page update completes before the data access. A read of 0x808 therefore returns the stored value with bits 18:13 cleared.
- R6: Ready rises after the third rising clock edge that follows the accepting edge. It stays high for exactly one cycle, and read data is valid during that cycle.
- R7: A request presented while the block is busy is ignored. It neither alters storage nor disturbs the access in progress.
- R8: Pages that are equal modulo PAGE_BANKS (default 4) share storage. For example, 0x1000 (page 4) and 0x2000 (page 8) address the same word.
- R9: The two low offset bits are ignored, so every access is to a whole 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request strobe, accepted only while idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_off_i | input | 16 | Logical byte offset |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | A sequence is in progress |
| rdy_o | output | 1 | One-cycle completion flag |
| rdata_o | output | 32 | Read data, valid with rdy_o |

## Verification
A page field captured wrongly, or a control read-modify-write that loses bits, becomes visible at the next read of 0x808. It also shows up as paged data landing in the wrong bank on the first read-back of a paged offset, within two accesses. A fault in the sequencer is seen within one access, as ready arriving on the wrong cycle, lasting more than one cycle, or a mid-sequence request changing stored data. The bench mixes random reads and writes across the direct region, several pages and the control register, and compares them against a bench-side model of the page update and the storage.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;
    localparam int OFF_W      = 16;
    localparam int DATA_W     = 32;
    localparam int BOUNDARY   = 'hC00;
    localparam int CTRL_OFF   = 'h808;
    localparam int PAGE_LSB   = 13;
    localparam int PAGE_W     = 6;
    localparam int WORD_W     = 10;
    localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'({PAGE_W{1'b1}}) << PAGE_LSB;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PGRD, ST_PGWR, ST_ACC, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [WORD_W-1:0] word;
    } xlate_t;

    function automatic xlate_t translate(input logic [OFF_W-1:0] off);
        xlate_t x;
        if (off < OFF_W'(BOUNDARY)) begin
            x.page = '0;
            x.word = off[11:2];
        end else begin
            x.page = off[15:10];
            x.word = {2'b11, off[9:2]};
        end
        return x;
    endfunction
endpackage

// File: rtl/pgw_xlate.sv
`timescale 1ns/1ps
module pgw_xlate
    import pgw_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    output xlate_t           x_o
);
    always_comb x_o = translate(off_i);
endmodule

// File: rtl/pgw_seq.sv
`timescale 1ns/1ps
module pgw_seq
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  req_t              req_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [DATA_W-1:0] ctrl_q_i,
    output req_t              req_q_o,
    output logic              busy_o,
    output logic              rdy_o,
    output logic              ctrl_we_o,
    output logic [DATA_W-1:0] ctrl_wd_o,
    output logic              acc_en_o
);
    seq_state_e        state;
    logic [DATA_W-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q_o <= '0;
            snap    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid_i) begin
                    req_q_o <= req_i;
                    state   <= ST_PGRD;
                end
                ST_PGRD: begin
                    snap  <= ctrl_q_i;
                    state <= ST_PGWR;
                end
                ST_PGWR: state <= ST_ACC;
                ST_ACC:  state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy_o    = (state != ST_IDLE);
        rdy_o     = (state == ST_DONE);
        ctrl_we_o = (state == ST_PGWR);
        acc_en_o  = (state == ST_ACC);
        ctrl_wd_o = (snap & ~PAGE_MASK) | (DATA_W'(page_i) << PAGE_LSB);
    end

    assert_rdy_single_R6: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);
    assert_page_before_data_R5: assert property (@(posedge clk) disable iff (rst)
        acc_en_o |-> $past(ctrl_we_o));
    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(req_q_o));
endmodule

// File: rtl/pgw_regs.sv
`timescale 1ns/1ps
module pgw_regs
    import pgw_pkg::*;
#(
    parameter int PAGE_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we_i,
    input  logic [DATA_W-1:0] ctrl_wd_i,
    input  logic              acc_en_i,
    input  logic              acc_we_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_q_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DIRECT_WORDS = BOUNDARY / 4;
    localparam int WIN_WORDS    = 256;
    localparam int BANK_W       = $clog2(PAGE_BANKS);
    localparam int PIDX_W       = BANK_W + 8;
    localparam int CTRL_WORD    = CTRL_OFF / 4;

    logic [DATA_W-1:0] dmem [DIRECT_WORDS];
    logic [DATA_W-1:0] pmem [PAGE_BANKS*WIN_WORDS];
    logic              in_win;
    logic [PIDX_W-1:0] pidx;

    always_comb begin
        ctrl_q_o = dmem[CTRL_WORD];
        in_win   = (word_i[9:8] == 2'b11);
        pidx     = {ctrl_q_o[PAGE_LSB +: BANK_W], word_i[7:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DIRECT_WORDS; i++) dmem[i] <= '0;
            for (int i = 0; i < PAGE_BANKS*WIN_WORDS; i++) pmem[i] <= '0;
            rdata_o <= '0;
        end else begin
            if (ctrl_we_i) dmem[CTRL_WORD] <= ctrl_wd_i;
            if (acc_en_i) begin
                if (acc_we_i) begin
                    if (in_win) pmem[pidx] <= wdata_i;
                    else        dmem[word_i] <= wdata_i;
                end else begin
                    rdata_o <= in_win ? pmem[pidx] : dmem[word_i];
                end
            end
        end
    end
endmodule

// File: rtl/pgw_window_dec.sv
`timescale 1ns/1ps
module pgw_window_dec
    import pgw_pkg::*;
#(
    parameter int PAGE_BANKS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [OFF_W-1:0]  req_off_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              busy_o,
    output logic              rdy_o,
    output logic [DATA_W-1:0] rdata_o
);
    req_t              req_in, req_q;
    xlate_t            xl;
    logic [DATA_W-1:0] ctrl_q, ctrl_wd;
    logic              ctrl_we, acc_en;

    always_comb begin
        req_in.we    = req_we_i;
        req_in.off   = req_off_i;
        req_in.wdata = req_wdata_i;
    end

    pgw_xlate u_xlate (.off_i(req_q.off), .x_o(xl));

    pgw_seq u_seq (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_i(req_in),
        .page_i(xl.page), .ctrl_q_i(ctrl_q), .req_q_o(req_q),
        .busy_o(busy_o), .rdy_o(rdy_o), .ctrl_we_o(ctrl_we),
        .ctrl_wd_o(ctrl_wd), .acc_en_o(acc_en)
    );

    pgw_regs #(.PAGE_BANKS(PAGE_BANKS)) u_regs (
        .clk(clk), .rst(rst), .ctrl_we_i(ctrl_we), .ctrl_wd_i(ctrl_wd),
        .acc_en_i(acc_en), .acc_we_i(req_q.we), .word_i(xl.word),
        .wdata_i(req_q.wdata), .ctrl_q_o(ctrl_q), .rdata_o(rdata_o)
    );

    assert_page_field_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q[PAGE_LSB +: PAGE_W] == $past(xl.page));
    assert_other_bits_kept_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (ctrl_q & ~PAGE_MASK) == $past(ctrl_q & ~PAGE_MASK));
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!busy_o && !rdy_o));
endmodule

// File: tb/pgw_window_dec_tb_top.sv
`timescale 1ns/1ps
module pgw_window_dec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rdy;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] mdl [int];

    always #4 clk = ~clk;

    pgw_window_dec dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_we_i(req_we),
        .req_off_i(req_off), .req_wdata_i(req_wdata),
        .busy_o(busy), .rdy_o(rdy), .rdata_o(rdata)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    function automatic int midx(input logic [15:0] off);
        logic [15:0] a = off & 16'hFFFC;
        if (a < 16'hC00) return int'(a >> 2);
        return 768 + int'((a >> 10) % 4) * 256 + int'((a & 16'h3FF) >> 2);
    endfunction

    function automatic logic [31:0] mget(input int i);
        return mdl.exists(i) ? mdl[i] : 32'h0;
    endfunction

    // Model: page update first, then the data access; returns the read value.
    function automatic logic [31:0] model(input bit we, input logic [15:0] off, input logic [31:0] wd);
        logic [5:0]  pg = (off < 16'hC00) ? 6'd0 : off[15:10];
        logic [31:0] c  = mget(16'h808 >> 2);
        mdl[16'h808 >> 2] = (c & ~(32'h3F << 13)) | (32'(pg) << 13);
        if (we) begin
            mdl[midx(off)] = wd;
            return 32'h0;
        end
        return mget(midx(off));
    endfunction

    task automatic access(input bit we, input logic [15:0] off, input logic [31:0] wd,
                          input bit inject, output logic [31:0] rd);
        int lat = 0;
        @(negedge clk);
        req_valid = 1; req_we = we; req_off = off; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (inject) begin
            req_we = 1; req_off = 16'h0100; req_wdata = 32'hBAD0BAD0;
        end else begin
            req_valid = 0;
        end
        while (!rdy && lat < 20) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        req_valid = 0;
        chk("R6 latency", 32'(lat), 32'd3);
        rd = rdata;
        @(posedge clk); @(negedge clk);
        chk("R6 single-cycle ready", {30'd0, rdy, busy}, 32'd0);
    endtask

    task automatic op(input string r, input bit we, input logic [15:0] off,
                      input logic [31:0] wd, input bit inject);
        logic [31:0] got, exp;
        exp = model(we, off, wd);
        access(we, off, wd, inject, got);
        if (!we) chk(r, got, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 idle after reset", {30'd0, rdy, busy}, 32'd0);
        op("R1 reset zero direct", 0, 16'h0000, 0, 0);
        op("R1 reset zero ctrl", 0, 16'h0808, 0, 0);
        op("R1 reset zero window", 0, 16'h1000, 0, 0);
        op("R2 direct", 1, 16'h0004, 32'hA5A5_0004, 0);
        op("R2 direct", 0, 16'h0004, 0, 0);
        op("R2 direct top", 1, 16'h0BFC, 32'h0BFC_0BFC, 0);
        op("R2 direct top", 0, 16'h0BFC, 0, 0);
        op("R3 page4", 1, 16'h1000, 32'h1111_0004, 0);
        op("R3 page5", 1, 16'h1400, 32'h2222_0005, 0);
        op("R3 page4 read", 0, 16'h1000, 0, 0);
        op("R3 page5 read", 0, 16'h1400, 0, 0);
        op("R3 page3 base", 1, 16'h0C00, 32'h3333_0003, 0);
        op("R3 page3 read", 0, 16'h0C00, 0, 0);
        op("R8 alias page8", 0, 16'h2000, 0, 0);
        op("R8 alias page7", 0, 16'h1C00, 0, 0);
        op("R8 alias page63", 1, 16'hFFFC, 32'h6363_6363, 0);
        op("R8 alias page3 top", 0, 16'h0FFC, 0, 0);
        op("R4 ctrl write", 1, 16'h0808, 32'hFFFF_FFFF, 0);
        op("R4 paged access", 0, 16'h1400, 0, 0);
        op("R4 enables kept", 0, 16'h0808, 0, 0);
        op("R5 ctrl write page", 1, 16'h0808, 32'h0007_E003, 0);
        op("R5 page cleared first", 0, 16'h0808, 0, 0);
        op("R9 low bits", 1, 16'h0013, 32'h0000_0013, 0);
        op("R9 low bits read", 0, 16'h0010, 0, 0);
        op("R9 low bits window", 0, 16'h1402, 0, 0);
        op("R7 injected write", 1, 16'h0020, 32'h7777_0020, 1);
        op("R7 injected read", 0, 16'h0020, 0, 1);
        op("R7 ignored target", 0, 16'h0100, 0, 0);
        for (int n = 0; n < 300; n++) begin
            logic [15:0] off;
            logic [31:0] r = $urandom;
            unique case (r[1:0])
                2'd0: off = 16'(($urandom % 16'hC00));
                2'd1: off = 16'h0C00 | 16'($urandom % 16'h400);
                2'd2: off = 16'((3 + ($urandom % 61)) << 10) | 16'($urandom % 16'h400);
                default: off = 16'h0808;
            endcase
            op("R3 random mix", r[2], off, $urandom, r[7:3] == 5'd0);
        end
        op("R7 ignored target final", 0, 16'h0100, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule